// File: doc/BRIEF.md
# Priority-Based Reference Input Selector

This block decides which of four reference clock inputs feeds one clock-synthesis loop. Each cycle it looks at the fault flags of every input, the loss-of-signal (LOS) masks, the rank programmed for each input and the switching mode. It then registers a selected input index and a state flag that says whether the loop is locked to an input, in holdover or in freerun.

Software picks the input directly in manual mode. In the two automatic modes the block picks the best-ranked input that is qualified. The revertive policy always moves back to a better input once that input recovers. The non-revertive policy keeps a working input until it fails. When the selection changes, the block raises a one-cycle switchover pulse. All inputs are plain synchronous levels. Every output is registered and reflects the inputs sampled at the previous rising clock edge.

Top module: `ref_input_selector`

## Requirements
- R1: When `sw_mode` is 0 (manual), `man_sel` is 0..3 and that input is qualified, the next cycle shows `locked`=1 and `sel_idx`=`man_sel`.
- R2: In manual mode, if `man_sel` is 4..7 or the chosen input is not qualified, the next cycle shows `locked`=0. The block is then in holdover (`holdover`=1) if `hist_valid` is 1, and in freerun (`freerun`=1) otherwise.
- R3: In `sw_mode` 1 or 2, the value of `man_sel` has no effect on any output.
- R4: Input i is qualified when `in_fault[i]`=0 and either `in_los[i]`=0 or `los_mask[i]`=1. A mask bit of 0 (the all-zero reset default) makes LOS count.
- R5: Input i's rank is `in_prio[3i+2:3i]`. Code 1 is best and code 4 is worst. Codes 0 and 5..7 mean the input is never selected automatically. When two inputs share a rank, the lower index wins.
- R6: With `sw_mode`=2 (revertive), the next cycle always selects the best-ranked qualified, selectable input. This includes switching back when a better input recovers.
- R7: With `sw_mode`=1 (non-revertive), a locked input stays selected while it is qualified and selectable. Otherwise the block moves to the best-ranked qualified, selectable input.
- R8: In an automatic mode with no qualified, selectable input, or with the reserved `sw_mode`=3, `locked` is 0 and holdover or freerun follows `hist_valid` as in R2.
- R9: Exactly one of `locked`, `holdover` and `freerun` is 1 in every cycle. While `locked`=0, `sel_idx` keeps its last value.
- R10: `sw_pulse` is 1 for one cycle when `locked` rises or `sel_idx` changes while locked, and is 0 otherwise.
- R11: During reset the outputs are `sel_idx`=0, `locked`=0, `holdover`=0, `freerun`=1 and `sw_pulse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_los | input | 4 | Loss-of-signal flag per input |
| in_fault | input | 4 | Other fault flag per input |
| los_mask | input | 4 | 1 = ignore that input's LOS |
| in_prio | input | 12 | 3-bit rank code per input, input i at [3i+2:3i] |
| sw_mode | input | 2 | 0 manual, 1 auto non-revertive, 2 auto revertive, 3 reserved |
| man_sel | input | 3 | Manual input choice, 4..7 reserved |
| hist_valid | input | 1 | Holdover history is usable |
| sel_idx | output | 2 | Selected input index |
| locked | output | 1 | Loop is following `sel_idx` |
| holdover | output | 1 | No input, history valid |
| freerun | output | 1 | No input, history not valid |
| sw_pulse | output | 1 | One-cycle switchover strobe |

## Verification
Because every decision is registered, a wrong internal selection or lock state shows up at `sel_idx` and the state flags exactly one cycle after the inputs that caused it. A missed or extra switchover appears as a wrong `sw_pulse` in that same cycle. A stale non-revertive "current input" stays hidden until the input it refers to fails or a better one recovers. For that reason the stimulus toggles faults on the selected input and moves the ranks around while each mode is held. Tie-breaking and rank mistakes only surface when two qualified inputs compete, so the random fault rates are kept low enough that competition is common.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
  typedef enum logic [1:0] {
    MODE_MANUAL   = 2'd0,
    MODE_AUTO_NR  = 2'd1,
    MODE_AUTO_REV = 2'd2,
    MODE_RSVD     = 2'd3
  } sw_mode_e;
endpackage

// File: rtl/ref_qualify.sv
module ref_qualify #(
  parameter int N      = 4,
  parameter int PRIO_W = 3
) (
  input  logic [N-1:0]        in_los,
  input  logic [N-1:0]        in_fault,
  input  logic [N-1:0]        los_mask,
  input  logic [N*PRIO_W-1:0] in_prio,
  output logic [N-1:0]        valid,
  output logic [N-1:0]        eligible
);
  // ranks 1..N are selectable; 0 and anything above N mean "never"
  localparam logic [PRIO_W-1:0] MAX_RANK = PRIO_W'(N);

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [PRIO_W-1:0] code;
    assign code        = in_prio[i*PRIO_W +: PRIO_W];
    assign valid[i]    = !in_fault[i] && !(in_los[i] && !los_mask[i]);
    assign eligible[i] = valid[i] && (code != '0) && (code <= MAX_RANK);
  end
endmodule

// File: rtl/ref_prio_pick.sv
module ref_prio_pick #(
  parameter int N      = 4,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]        eligible,
  input  logic [N*PRIO_W-1:0] in_prio,
  output logic [IDX_W-1:0]    best_idx,
  output logic                best_ok
);
  // scan rank first, then index, so equal ranks fall to the lower index
  always_comb begin
    best_ok  = 1'b0;
    best_idx = '0;
    for (int r = 1; r <= N; r++) begin
      for (int i = 0; i < N; i++) begin
        if (!best_ok && eligible[i] &&
            in_prio[i*PRIO_W +: PRIO_W] == PRIO_W'(r)) begin
          best_ok  = 1'b1;
          best_idx = IDX_W'(i);
        end
      end
    end
  end

  // R5
  always_comb begin
    if (best_ok) begin
      best_elig_chk: assert (eligible[best_idx]);
    end
  end
endmodule

// File: rtl/ref_sel_ctrl.sv
module ref_sel_ctrl
  import ref_sel_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N),
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sw_mode,
  input  logic [SEL_W-1:0] man_sel,
  input  logic             hist_valid,
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     eligible,
  input  logic [IDX_W-1:0] best_idx,
  input  logic             best_ok,
  output logic [IDX_W-1:0] sel_idx,
  output logic             locked,
  output logic             holdover,
  output logic             freerun,
  output logic             sw_pulse
);
  sw_mode_e         mode;
  logic             man_ok;
  logic             nxt_ok;
  logic [IDX_W-1:0] nxt_idx;
  logic             past_ok;

  assign mode   = sw_mode_e'(sw_mode);
  assign man_ok = (int'(man_sel) < N) && valid[man_sel[IDX_W-1:0]];

  always_comb begin
    nxt_ok  = 1'b0;
    nxt_idx = sel_idx;
    unique case (mode)
      MODE_MANUAL: begin
        if (man_ok) begin
          nxt_ok  = 1'b1;
          nxt_idx = man_sel[IDX_W-1:0];
        end
      end
      MODE_AUTO_NR: begin
        if (locked && eligible[sel_idx]) begin
          nxt_ok = 1'b1;
        end else if (best_ok) begin
          nxt_ok  = 1'b1;
          nxt_idx = best_idx;
        end
      end
      MODE_AUTO_REV: begin
        if (best_ok) begin
          nxt_ok  = 1'b1;
          nxt_idx = best_idx;
        end
      end
      default: nxt_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_idx  <= '0;
      locked   <= 1'b0;
      holdover <= 1'b0;
      freerun  <= 1'b1;
      sw_pulse <= 1'b0;
      past_ok  <= 1'b0;
    end else begin
      sel_idx  <= nxt_idx;
      locked   <= nxt_ok;
      holdover <= !nxt_ok && hist_valid;
      freerun  <= !nxt_ok && !hist_valid;
      sw_pulse <= nxt_ok && (!locked || nxt_idx != sel_idx);
      past_ok  <= 1'b1;
    end
  end

  // R9
  one_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({locked, holdover, freerun}) == 1);

  // R9
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !locked |-> $stable(sel_idx));

  // R10
  pulse_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pulse |-> locked);

  // R10
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(locked) |-> sw_pulse);

  // R1
  manual_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode == MODE_MANUAL && man_ok) |->
      locked && sel_idx == $past(man_sel[IDX_W-1:0]));

  // R6
  revert_best_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode == MODE_AUTO_REV && best_ok) |->
      locked && sel_idx == $past(best_idx));

  // R7
  nonrev_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode == MODE_AUTO_NR && locked && eligible[sel_idx]) |->
      locked && $stable(sel_idx));

  // R8
  rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode == MODE_RSVD) |-> !locked);
endmodule

// File: rtl/ref_input_selector.sv
module ref_input_selector #(
  parameter int N      = 4,
  parameter int PRIO_W = 3,
  parameter int SEL_W  = 3,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        in_los,
  input  logic [N-1:0]        in_fault,
  input  logic [N-1:0]        los_mask,
  input  logic [N*PRIO_W-1:0] in_prio,
  input  logic [1:0]          sw_mode,
  input  logic [SEL_W-1:0]    man_sel,
  input  logic                hist_valid,
  output logic [IDX_W-1:0]    sel_idx,
  output logic                locked,
  output logic                holdover,
  output logic                freerun,
  output logic                sw_pulse
);
  logic [N-1:0]     valid;
  logic [N-1:0]     eligible;
  logic [IDX_W-1:0] best_idx;
  logic             best_ok;

  ref_qualify #(.N(N), .PRIO_W(PRIO_W)) u_qual (
    .in_los   (in_los),
    .in_fault (in_fault),
    .los_mask (los_mask),
    .in_prio  (in_prio),
    .valid    (valid),
    .eligible (eligible)
  );

  ref_prio_pick #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .eligible (eligible),
    .in_prio  (in_prio),
    .best_idx (best_idx),
    .best_ok  (best_ok)
  );

  ref_sel_ctrl #(.N(N), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_mode    (sw_mode),
    .man_sel    (man_sel),
    .hist_valid (hist_valid),
    .valid      (valid),
    .eligible   (eligible),
    .best_idx   (best_idx),
    .best_ok    (best_ok),
    .sel_idx    (sel_idx),
    .locked     (locked),
    .holdover   (holdover),
    .freerun    (freerun),
    .sw_pulse   (sw_pulse)
  );
endmodule

// File: tb/ref_input_selector_tb.sv
module ref_input_selector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  los = '0, flt = '0, msk = '0;
  logic [11:0] pri = 12'b100_011_010_001;
  logic [1:0]  md = 2'd0;
  logic [2:0]  ms = 3'd0;
  logic        hv = 1'b0;
  logic [1:0]  sel_idx;
  logic        locked, holdover, freerun, sw_pulse;

  int n_tests = 0;
  int n_fail  = 0;

  bit       m_lock, m_hold, m_free, m_pulse;
  bit [1:0] m_sel;

  always #5ns clk = ~clk;

  ref_input_selector u_dut (
    .clk(clk), .rst_n(rst_n), .in_los(los), .in_fault(flt), .los_mask(msk),
    .in_prio(pri), .sw_mode(md), .man_sel(ms), .hist_valid(hv),
    .sel_idx(sel_idx), .locked(locked), .holdover(holdover),
    .freerun(freerun), .sw_pulse(sw_pulse)
  );

  function automatic int rank_of(int i);
    int c = int'(pri[3*i +: 3]);
    return (c >= 1 && c <= 4) ? c : 0;
  endfunction

  task automatic compare(string tag, logic [5:0] act, logic [5:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {sel,lock,hold,free,pulse} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // apply the current stimulus for one edge and check the registered result
  task automatic step(string tag);
    bit [3:0] v, e;
    bit bok, tok;
    int bi;
    bit [1:0] tr;
    for (int i = 0; i < 4; i++) begin
      v[i] = !flt[i] && !(los[i] && !msk[i]);
      e[i] = v[i] && rank_of(i) != 0;
    end
    bok = 0; bi = 0;
    for (int i = 0; i < 4; i++)
      if (e[i] && (!bok || rank_of(i) < rank_of(bi))) begin bok = 1; bi = i; end
    tok = 0; tr = m_sel;
    case (md)
      2'd0: if (ms < 3'd4 && v[ms[1:0]]) begin tok = 1; tr = ms[1:0]; end
      2'd1: if (m_lock && e[m_sel]) tok = 1;
            else if (bok) begin tok = 1; tr = 2'(bi); end
      2'd2: if (bok) begin tok = 1; tr = 2'(bi); end
      default: tok = 0;
    endcase
    m_pulse = tok && (!m_lock || tr != m_sel);
    m_lock  = tok;
    if (tok) m_sel = tr;
    m_hold = !tok && hv;
    m_free = !tok && !hv;
    @(negedge clk);
    compare(tag, {sel_idx, locked, holdover, freerun, sw_pulse},
            {m_sel, m_lock, m_hold, m_free, m_pulse});
  endtask

  initial begin
    #2ms;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset values
    compare("R11", {sel_idx, locked, holdover, freerun, sw_pulse}, 6'b00_0010);
    rst_n = 1'b1;
    m_sel = 0; m_lock = 0; m_hold = 0; m_free = 1; m_pulse = 0;

    // R1 manual pick, then hold (R10 pulse one cycle)
    hv = 1; md = 2'd0; ms = 3'd2;
    step("R1");
    compare("R1", {sel_idx, locked, sw_pulse}, 4'b10_1_1);
    step("R10");
    compare("R10", {1'b0, sw_pulse}, 2'b00);
    // R2 reserved select and faulted choice
    ms = 3'd5; step("R2");
    compare("R2", {locked, holdover, freerun}, 3'b010);
    ms = 3'd3; flt = 4'b1000; hv = 0; step("R2");
    compare("R2", {locked, holdover, freerun}, 3'b001);
    compare("R9", {1'b0, sel_idx}, 3'b010);
    flt = 0; hv = 1;
    // R3 man_sel ignored in revertive mode
    md = 2'd2; ms = 3'd3; step("R3");
    compare("R3", {sel_idx, locked}, 3'b00_1);
    ms = 3'd1; step("R3");
    // R4 LOS counts unless masked
    los = 4'b0001; step("R4");
    compare("R4", {1'b0, sel_idx}, 3'b001);
    msk = 4'b0001; step("R4");
    compare("R4", {1'b0, sel_idx}, 3'b000);
    los = 0; msk = 0;
    // R5 never-select, ties, reserved codes
    pri = 12'b100_011_010_000; step("R5");
    pri = 12'b001_001_000_000; step("R5");
    compare("R5", {1'b0, sel_idx}, 3'b010);
    pri = 12'b110_010_111_101; step("R5");
    pri = 12'b100_011_010_001;
    // R6 revert back after recovery
    step("R6");
    flt = 4'b0001; step("R6");
    flt = 4'b0000; step("R6");
    compare("R6", {sel_idx, sw_pulse}, 3'b00_1);
    // R7 non-revertive stays
    md = 2'd1; flt = 4'b0001; step("R7");
    flt = 4'b0000; step("R7");
    compare("R7", {sel_idx, sw_pulse}, 3'b01_0);
    // R8 nothing eligible, reserved mode
    flt = 4'b1111; step("R8");
    hv = 0; step("R8");
    flt = 0; md = 2'd3; step("R8");
    hv = 1; step("R8");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      string tg;
      if (n % 25 == 0) md = 2'($urandom_range(0, 3));
      if (n % 40 == 0) begin
        for (int i = 0; i < 4; i++)
          pri[3*i +: 3] = ($urandom_range(0, 9) < 8) ? 3'($urandom_range(1, 4))
                                                     : 3'($urandom_range(0, 7));
        msk = 4'($urandom);
      end
      for (int i = 0; i < 4; i++) begin
        flt[i] = ($urandom_range(0, 7) == 0);
        los[i] = ($urandom_range(0, 5) == 0);
      end
      ms = 3'($urandom_range(0, 7));
      if (n % 13 == 0) hv = 1'($urandom);
      case (md)
        2'd0: tg = "R2";
        2'd1: tg = "R7";
        2'd2: tg = "R6";
        default: tg = "R8";
      endcase
      step(tg);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule